// File: doc/BRIEF.md
# Dirty Region Bulk Writeback Engine

This block sits beside the last-level cache and keeps a record of memory regions that an upstream density tracker has judged to be modified and densely used. A region is 1 KB, which is sixteen 64-byte blocks. The tracker hands over the region address of each such region when it drops the region from its own table. The engine stores these region addresses in a set-associative table.

The engine watches the cache's eviction stream. A clean eviction is ignored. A dirty eviction looks up its region in the table. On a hit the entry is consumed, and the engine sends the cache one writeback request for each of the other fifteen blocks of that region. The requests leave one per cycle on a valid/ready stream, in ascending block order. The cache can then write the whole region to DRAM while the row is open. A region fires at most once for each insertion.

A hit that arrives while a burst is still draining is held in a single pending slot. While that slot is occupied, the eviction input is stalled.

Top module: `dirty_region_wb`

## Requirements
- R1: After reset, `wbValid` is low, `evReady` is high and the table holds no regions, so a dirty eviction produces no writeback.
- R2: After a region R has been inserted, a dirty eviction of block b in R produces exactly fifteen writeback addresses. Each address is `{R, i, 6'b0}` for i = 0..15 with i != b, issued in ascending i. The region is the address shifted right by 10 and the block index is address bits [9:6]. The first address is valid in the cycle after the eviction is accepted.
- R3: A clean eviction (`evDirty` low) neither produces a writeback nor removes the entry, so a later dirty eviction of the same region still fires.
- R4: A hit consumes its entry. A second dirty eviction to the same region, with no new insert, produces nothing.
- R5: A dirty eviction whose region is not in the table produces nothing.
- R6: While `wbValid` is high and `wbReady` is low, `wbValid` stays high and `wbAddr` holds its value.
- R7: A hit accepted while a burst is draining is kept in one pending slot. `evReady` is low from the next cycle until the pending burst starts. Bursts are issued in the order their evictions were accepted.
- R8: The set is chosen by region-address bits [5:0], and each set has 16 ways that are filled from way 0 upward. An insert into a full set silently replaces the way named by that set's round-robin pointer, which starts at way 0 and advances once per replacement. The 17th distinct region inserted into one set therefore displaces the first.
- R9: Inserting a region that is already present adds no second entry, so that region fires only once.
- R10: When the evicted block is block 0, the burst runs over blocks 1..15. When it is block 15, the burst runs over blocks 0..14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert a region into the table this cycle |
| insRegion | input | 22 | Region address to insert (physical address >> 10) |
| evValid | input | 1 | Eviction present |
| evDirty | input | 1 | The evicted block was modified |
| evBlock | input | 26 | Evicted block address (physical address >> 6) |
| evReady | output | 1 | Eviction accepted when high together with evValid |
| wbValid | output | 1 | Writeback address valid |
| wbReady | input | 1 | The cache takes the writeback address |
| wbAddr | output | 32 | 64-byte aligned writeback byte address |

## Verification
A stale valid bit or a wrong tag in the table shows up as a whole burst that appears or goes missing. That happens in the cycle after the dirty eviction that probes the entry, so every test drains and confirms the absence of stray beats before the next test starts. A corrupted skip index or counter shows up inside a burst as a wrong, repeated or missing block address, which the scoreboard catches on the offending beat. A mishandled pending slot shows up as `evReady` not falling after a second hit, or as bursts coming out of order. Replacement state is only visible later, through which of the seventeen regions sharing a set still fire.

// File: rtl/drw_pkg.sv
package drw_pkg;
  typedef struct packed {
    logic insert;
    logic consume;
  } drwStrobe_t;
endpackage

// File: rtl/dirty_region_table.sv
module dirty_region_table
  import drw_pkg::*;
#(
  parameter int REG_W   = 22,
  parameter int ENTRIES = 1024,
  parameter int WAYS    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  drwStrobe_t       strobe,
  input  logic [REG_W-1:0] insRegion,
  input  logic [REG_W-1:0] probeRegion,
  output logic [WAYS-1:0]  hitVec
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = REG_W - SET_W;

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic [WAYS-1:0]  validMem [SETS];
  logic [WAY_W-1:0] rrPtr    [SETS];

  logic [SET_W-1:0] pSet, iSet;
  logic [TAG_W-1:0] pTag, iTag;
  logic [WAYS-1:0]  dupVec, freeVec;
  logic [WAY_W-1:0] hitWay, freeWay, victimWay;
  logic             anyFree, insDup, doIns;

  assign pSet = probeRegion[SET_W-1:0];
  assign pTag = probeRegion[REG_W-1:SET_W];
  assign iSet = insRegion[SET_W-1:0];
  assign iTag = insRegion[REG_W-1:SET_W];

  // one comparator per way for the probe port and for the insert port
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w] = validMem[pSet][w] && (tagMem[pSet][w] == pTag);
    assign dupVec[w] = validMem[iSet][w] && (tagMem[iSet][w] == iTag);
  end

  assign freeVec = ~validMem[iSet];
  assign anyFree = |freeVec;
  assign insDup  = |dupVec;
  assign doIns   = strobe.insert && !insDup;

  always_comb begin
    freeWay = '0;
    hitWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (freeVec[w]) freeWay = WAY_W'(w);
      if (hitVec[w])  hitWay  = WAY_W'(w);
    end
  end

  assign victimWay = anyFree ? freeWay : rrPtr[iSet];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        rrPtr[s]    <= '0;
      end
    end else begin
      if (strobe.consume) validMem[pSet][hitWay] <= 1'b0;
      if (doIns) begin
        validMem[iSet][victimWay] <= 1'b1;
        if (!anyFree) rrPtr[iSet] <= rrPtr[iSet] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doIns) tagMem[iSet][victimWay] <= iTag;
  end
endmodule

// File: rtl/dirty_region_burst.sv
module dirty_region_burst
  import drw_pkg::*;
#(
  parameter int PA_W         = 32,
  parameter int REGION_SHIFT = 10,
  parameter int BLOCK_SHIFT  = 6,
  parameter int WAYS         = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        insValid,
  input  logic                        evValid,
  input  logic                        evDirty,
  input  logic [PA_W-BLOCK_SHIFT-1:0] evBlock,
  output logic                        evReady,
  input  logic [WAYS-1:0]             hitVec,
  output drwStrobe_t                  strobe,
  output logic [PA_W-REGION_SHIFT-1:0] probeRegion,
  output logic                        wbValid,
  input  logic                        wbReady,
  output logic [PA_W-1:0]             wbAddr
);
  localparam int IDX_W = REGION_SHIFT - BLOCK_SHIFT;
  localparam int REG_W = PA_W - REGION_SHIFT;
  localparam logic [IDX_W-1:0] MAX_IDX = {IDX_W{1'b1}};

  logic             activeValid, pendValid;
  logic [REG_W-1:0] actRegion, pendRegion;
  logic [IDX_W-1:0] actSkip, pendSkip, cnt, lastIdx, nextIdx, evIdx;
  logic             probe, hit, beat, finishing, freeSlot;
  logic             loadFromPend, loadFromHit, hitToPend;

  function automatic logic [IDX_W-1:0] firstIdx(input logic [IDX_W-1:0] skip);
    return (skip == '0) ? IDX_W'(1) : '0;
  endfunction

  assign probeRegion = evBlock[PA_W-BLOCK_SHIFT-1:IDX_W];
  assign evIdx       = evBlock[IDX_W-1:0];
  assign evReady     = !pendValid;
  assign probe       = evValid && evReady && evDirty;
  assign hit         = probe && (|hitVec);

  assign strobe.insert  = insValid;
  assign strobe.consume = hit;

  assign lastIdx   = (actSkip == MAX_IDX) ? MAX_IDX - 1'b1 : MAX_IDX;
  assign beat      = activeValid && wbReady;
  assign finishing = beat && (cnt == lastIdx);
  assign freeSlot  = !activeValid || finishing;

  assign loadFromPend = freeSlot && pendValid;
  assign loadFromHit  = freeSlot && !pendValid && hit;
  assign hitToPend    = hit && !loadFromHit;

  always_comb begin
    nextIdx = cnt + 1'b1;
    if (nextIdx == actSkip) nextIdx = cnt + IDX_W'(2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeValid <= 1'b0;
      pendValid   <= 1'b0;
      actRegion   <= '0;
      actSkip     <= '0;
      cnt         <= '0;
      pendRegion  <= '0;
      pendSkip    <= '0;
    end else begin
      if (loadFromPend) begin
        activeValid <= 1'b1;
        actRegion   <= pendRegion;
        actSkip     <= pendSkip;
        cnt         <= firstIdx(pendSkip);
        pendValid   <= 1'b0;
      end else if (loadFromHit) begin
        activeValid <= 1'b1;
        actRegion   <= probeRegion;
        actSkip     <= evIdx;
        cnt         <= firstIdx(evIdx);
      end else if (finishing) begin
        activeValid <= 1'b0;
      end else if (beat) begin
        cnt <= nextIdx;
      end
      if (hitToPend) begin
        pendValid  <= 1'b1;
        pendRegion <= probeRegion;
        pendSkip   <= evIdx;
      end
    end
  end

  assign wbValid = activeValid;
  assign wbAddr  = {actRegion, cnt, {BLOCK_SHIFT{1'b0}}};
endmodule

// File: rtl/dirty_region_wb.sv
module dirty_region_wb
  import drw_pkg::*;
#(
  parameter int PA_W         = 32,
  parameter int REGION_SHIFT = 10,
  parameter int BLOCK_SHIFT  = 6,
  parameter int ENTRIES      = 1024,
  parameter int WAYS         = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          insValid,
  input  logic [PA_W-REGION_SHIFT-1:0]  insRegion,
  input  logic                          evValid,
  input  logic                          evDirty,
  input  logic [PA_W-BLOCK_SHIFT-1:0]   evBlock,
  output logic                          evReady,
  output logic                          wbValid,
  input  logic                          wbReady,
  output logic [PA_W-1:0]               wbAddr
);
  localparam int REG_W = PA_W - REGION_SHIFT;

  drwStrobe_t       strobe;
  logic [WAYS-1:0]  hitVec;
  logic [REG_W-1:0] probeRegion;

  dirty_region_table #(.REG_W(REG_W), .ENTRIES(ENTRIES), .WAYS(WAYS)) u_table (
    .clk(clk), .rstN(rstN), .strobe(strobe), .insRegion(insRegion),
    .probeRegion(probeRegion), .hitVec(hitVec)
  );

  dirty_region_burst #(.PA_W(PA_W), .REGION_SHIFT(REGION_SHIFT),
                       .BLOCK_SHIFT(BLOCK_SHIFT), .WAYS(WAYS)) u_burst (
    .clk(clk), .rstN(rstN), .insValid(insValid), .evValid(evValid),
    .evDirty(evDirty), .evBlock(evBlock), .evReady(evReady), .hitVec(hitVec),
    .strobe(strobe), .probeRegion(probeRegion), .wbValid(wbValid),
    .wbReady(wbReady), .wbAddr(wbAddr)
  );
endmodule

// File: rtl/dirty_region_wb_chk.sv
module dirty_region_wb_chk #(
  parameter int PA_W         = 32,
  parameter int REGION_SHIFT = 10,
  parameter int BLOCK_SHIFT  = 6,
  parameter int WAYS         = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            evReady,
  input logic            wbValid,
  input logic            wbReady,
  input logic [PA_W-1:0] wbAddr,
  input logic [WAYS-1:0] hitVec
);
  localparam int IDX_W = REGION_SHIFT - BLOCK_SHIFT;
  localparam logic [IDX_W-1:0] BURST_LEN = {IDX_W{1'b1}};

  logic [IDX_W-1:0] beatCnt;
  logic [PA_W-1:0]  lastAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt  <= '0;
      lastAddr <= '0;
    end else if (wbValid && wbReady) begin
      lastAddr <= wbAddr;
      beatCnt  <= (beatCnt == BURST_LEN - 1'b1) ? '0 : beatCnt + 1'b1;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbAddr)));

  p_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbAddr[BLOCK_SHIFT-1:0] == '0));

  p_ascend_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbReady && beatCnt != '0) |->
      (wbAddr[PA_W-1:REGION_SHIFT] == lastAddr[PA_W-1:REGION_SHIFT] &&
       wbAddr[REGION_SHIFT-1:BLOCK_SHIFT] > lastAddr[REGION_SHIFT-1:BLOCK_SHIFT]));

  p_single_entry_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  p_stall_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(evReady) |-> $past(wbValid));
endmodule

bind dirty_region_wb dirty_region_wb_chk #(
  .PA_W(PA_W), .REGION_SHIFT(REGION_SHIFT), .BLOCK_SHIFT(BLOCK_SHIFT), .WAYS(WAYS)
) u_chk (
  .clk(clk), .rstN(rstN), .evReady(evReady), .wbValid(wbValid),
  .wbReady(wbReady), .wbAddr(wbAddr), .hitVec(hitVec)
);

// File: tb/test_dirty_region_wb.sv
`timescale 1ns/1ps
module test_dirty_region_wb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        insValid = 1'b0;
  logic [21:0] insRegion = '0;
  logic        evValid = 1'b0;
  logic        evDirty = 1'b0;
  logic [25:0] evBlock = '0;
  logic        evReady;
  logic        wbValid;
  logic        wbReady = 1'b1;
  logic [31:0] wbAddr;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit readyMode = 0;
  string curReq = "R1";
  logic [31:0] expQ[$];
  bit prevStall = 0;
  logic [31:0] prevAddr = '0;

  dirty_region_wb i_dirty_region_wb (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insRegion(insRegion),
    .evValid(evValid), .evDirty(evDirty), .evBlock(evBlock), .evReady(evReady),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    #1 wbReady = readyMode ? (cyc % 3 != 0) : 1'b1;
  end

  // monitor: compares accepted beats with the scoreboard queue
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) check(wbValid && wbAddr == prevAddr, "R6", wbAddr, prevAddr);
      prevStall = wbValid && !wbReady;
      prevAddr  = wbAddr;
      if (wbValid && wbReady) begin
        if (expQ.size() == 0) check(0, {curReq, " unexpected writeback"}, wbAddr, 32'h0);
        else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(wbAddr == e, curReq, wbAddr, e);
        end
      end
    end
  end

  task automatic expectBurst(input logic [21:0] r, input int skip);
    for (int i = 0; i < 16; i++)
      if (i != skip) expQ.push_back({r, 4'(i), 6'b0});
  endtask

  task automatic doInsert(input logic [21:0] r);
    @(posedge clk); #1;
    insValid = 1'b1; insRegion = r;
    @(posedge clk); #1;
    insValid = 1'b0;
  endtask

  task automatic doEvict(input logic [21:0] r, input int blk, input bit dirty);
    @(posedge clk); #1;
    evValid = 1'b1; evDirty = dirty; evBlock = {r, 4'(blk)};
    do @(negedge clk); while (!evReady);
    @(posedge clk); #1;
    evValid = 1'b0; evDirty = 1'b0;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while ((expQ.size() != 0 || wbValid) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (25) @(negedge clk);
    check(expQ.size() == 0 && !wbValid, {req, " drained"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    check(wbValid == 1'b0, "R1 wbValid", wbValid, 0);
    check(evReady == 1'b1, "R1 evReady", evReady, 1);
    doEvict(22'h00ABC, 4, 1);
    drain("R1");

    curReq = "R5";
    doInsert(22'h001C0);
    doEvict(22'h002C0, 4, 1);
    drain("R5");

    curReq = "R2";
    doInsert(22'h12345);
    expectBurst(22'h12345, 7);
    doEvict(22'h12345, 7, 1);
    @(negedge clk);
    check(wbValid == 1'b1, "R2 first beat timing", wbValid, 1);
    drain("R2");

    curReq = "R4";
    doEvict(22'h12345, 2, 1);
    drain("R4");

    curReq = "R3";
    doInsert(22'h0BEEF);
    doEvict(22'h0BEEF, 3, 0);
    drain("R3 clean");
    expectBurst(22'h0BEEF, 9);
    doEvict(22'h0BEEF, 9, 1);
    drain("R3");

    curReq = "R10";
    doInsert(22'h00011);
    doInsert(22'h00022);
    expectBurst(22'h00011, 0);
    doEvict(22'h00011, 0, 1);
    drain("R10 block0");
    expectBurst(22'h00022, 15);
    doEvict(22'h00022, 15, 1);
    drain("R10 block15");

    curReq = "R6";
    readyMode = 1;
    doInsert(22'h3F00F);
    expectBurst(22'h3F00F, 5);
    doEvict(22'h3F00F, 5, 1);
    drain("R6");
    readyMode = 0;

    curReq = "R7";
    doInsert(22'h00A01);
    doInsert(22'h00B02);
    doInsert(22'h00C03);
    expectBurst(22'h00A01, 1);
    expectBurst(22'h00B02, 8);
    expectBurst(22'h00C03, 14);
    doEvict(22'h00A01, 1, 1);
    doEvict(22'h00B02, 8, 1);
    @(negedge clk);
    check(evReady == 1'b0, "R7 stall", evReady, 0);
    doEvict(22'h00C03, 14, 1);
    drain("R7");

    curReq = "R8";
    for (int k = 1; k <= 17; k++) doInsert({16'(k), 6'd5});
    doEvict({16'd1, 6'd5}, 3, 1);
    drain("R8 displaced");
    expectBurst({16'd2, 6'd5}, 6);
    doEvict({16'd2, 6'd5}, 6, 1);
    drain("R8 kept");
    expectBurst({16'd17, 6'd5}, 10);
    doEvict({16'd17, 6'd5}, 10, 1);
    drain("R8 newcomer");

    curReq = "R9";
    doInsert(22'h2D2D2);
    doInsert(22'h2D2D2);
    expectBurst(22'h2D2D2, 12);
    doEvict(22'h2D2D2, 12, 1);
    drain("R9 first");
    doEvict(22'h2D2D2, 4, 1);
    drain("R9 once");

    finishRun();
  end
endmodule